// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Register

This block merges seven independent reset requests into a single system reset output, and keeps a 16-bit status word that records which request caused each reset. The requests are power-on, brown-out, an external active-low clear pin, a software reset strobe, a watchdog timeout, a trap-conflict event, and an illegal-opcode or uninitialized-register event. The analog detectors sit outside the block and arrive as plain digital flags. The clear pin passes through a digital glitch filter before it counts as a request.

Once asserted, the system reset output stays high for a fixed hold time after the last request goes away, and it is released on a clock edge. Software reads the cause word directly. It can overwrite the word through a single write strobe, which changes only status and never starts a reset. Cause bits are sticky: they build up across resets until software clears them. A power-on request wipes the word down to the power-on bit alone.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Whenever any of the seven requests is active at a clock edge (the clear pin counting only once filtered), `sys_rst_o` is 1 after that edge.
- R2: `sys_rst_o` falls on the 16th consecutive clock edge at which no request is active, and not earlier.
- R3: While `rst_ni` is low and just after it rises, `sys_rst_o` is 1 and `cause_o` is 16'h0001.
- R4: Each request sets its own cause bit at the edge where it is seen: bit 0 power-on, bit 1 brown-out, bit 2 watchdog, bit 6 software, bit 7 filtered clear pin, bit 14 illegal opcode or uninitialized register, bit 15 trap conflict.
- R5: A power-on request at an edge leaves `cause_o` equal to 16'h0001, whatever it held before.
- R6: Cause bits other than power-on are sticky. A bit once set stays set through later resets until software writes it to 0.
- R7: With `sys_rst_o` low, `reg_we_i` loads `reg_wdata_i` into the implemented cause bits at the next edge. A write on its own never asserts `sys_rst_o`.
- R8: Writes are ignored while `sys_rst_o` is 1.
- R9: If a request and a write that clears its bit fall in the same cycle, the bit ends up set.
- R10: Bits 3, 4, 5 and 8 to 13 of `cause_o` always read 0, including after a write of all ones.
- R11: The clear pin counts as asserted only after it has been sampled low at 4 consecutive edges, and it is released after 4 consecutive high samples. A low pulse of 3 clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low register initialisation |
| pwr_on_i | input | 1 | Power-on detector flag |
| brown_out_i | input | 1 | Brown-out detector flag |
| ext_clr_ni | input | 1 | External clear pin, active low, unfiltered |
| sw_rst_i | input | 1 | Software reset instruction strobe |
| wdog_i | input | 1 | Watchdog timeout |
| trap_conf_i | input | 1 | Trap-conflict event |
| bad_op_i | input | 1 | Illegal opcode or uninitialized register use |
| reg_we_i | input | 1 | Cause word write strobe |
| reg_wdata_i | input | 16 | Cause word write data |
| cause_o | output | 16 | Cause word read value |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The bench targets the hold-time boundary. A timer that is off by one releases `sys_rst_o` on the 15th or the 17th idle edge. The glitch filter is checked with a 3-clock and a 6-clock low pulse on the clear pin: a filter with the wrong depth either passes the short pulse or blocks the long one. Same-cycle races are also covered. A watchdog event arriving together with a clearing write must leave bit 2 set. A write while reset is held must not land. A power-on request arriving while many sticky bits are set must collapse the word to 16'h0001. A write of all ones probes the reserved positions, which a design without a mask would leave set.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int CAUSE_W  = 16;
  localparam int B_PWR    = 0;
  localparam int B_BROWN  = 1;
  localparam int B_WDOG   = 2;
  localparam int B_SW     = 6;
  localparam int B_PIN    = 7;
  localparam int B_BADOP  = 14;
  localparam int B_TRAP   = 15;

  typedef logic [CAUSE_W-1:0] cause_t;

  typedef struct packed {
    logic pwr;
    logic brown;
    logic pin;
    logic sw;
    logic wdog;
    logic trap;
    logic badop;
  } src_t;

  function automatic cause_t impl_mask();
    cause_t m = '0;
    m[B_PWR] = 1'b1; m[B_BROWN] = 1'b1; m[B_WDOG] = 1'b1; m[B_SW] = 1'b1;
    m[B_PIN] = 1'b1; m[B_BADOP] = 1'b1; m[B_TRAP] = 1'b1;
    return m;
  endfunction

  function automatic cause_t src_to_bits(src_t s);
    cause_t v = '0;
    v[B_PWR]   = s.pwr;
    v[B_BROWN] = s.brown;
    v[B_WDOG]  = s.wdog;
    v[B_SW]    = s.sw;
    v[B_PIN]   = s.pin;
    v[B_BADOP] = s.badop;
    v[B_TRAP]  = s.trap;
    return v;
  endfunction
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic hit_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          state_q;
  logic [CW-1:0] cnt_q;
  logic          raw;

  assign raw = ~pin_ni;

  // state flips only after FILT_LEN consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (raw != state_q) begin
      if (cnt_q == LAST) begin
        state_q <= raw;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign hit_o = state_q;
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LOAD;
    else if (req_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = (cnt_q != '0);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pwr_i,
  input  cause_t ev_i,
  input  logic   wr_ok_i,
  input  cause_t wdata_i,
  output cause_t cause_o
);
  localparam cause_t MASK = impl_mask();

  logic unused_wdata;
  assign unused_wdata = ^(wdata_i & ~MASK) ^ ^(ev_i & ~MASK);

  for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      localparam logic RST_VAL = (b == B_PWR);
      logic bit_q;
      // event OR-ed after the write so it wins over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      bit_q <= RST_VAL;
        else if (pwr_i)   bit_q <= RST_VAL;
        else              bit_q <= ev_i[b] | (wr_ok_i ? wdata_i[b] : bit_q);
      end
      assign cause_o[b] = bit_q;
    end else begin : g_tie
      assign cause_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_CYC = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_on_i,
  input  logic        brown_out_i,
  input  logic        ext_clr_ni,
  input  logic        sw_rst_i,
  input  logic        wdog_i,
  input  logic        trap_conf_i,
  input  logic        bad_op_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] cause_o,
  output logic        sys_rst_o
);
  logic   pin_hit;
  src_t   src;
  logic   any_req;
  cause_t ev_bits;

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_ni(ext_clr_ni),
    .hit_o (pin_hit)
  );

  always_comb begin
    src.pwr   = pwr_on_i;
    src.brown = brown_out_i;
    src.pin   = pin_hit;
    src.sw    = sw_rst_i;
    src.wdog  = wdog_i;
    src.trap  = trap_conf_i;
    src.badop = bad_op_i;
  end

  assign any_req = |src;
  assign ev_bits = src_to_bits(src);

  rst_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (any_req),
    .rst_o (sys_rst_o)
  );

  rst_cause_reg u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwr_i  (pwr_on_i),
    .ev_i   (ev_bits),
    .wr_ok_i(reg_we_i & ~sys_rst_o),
    .wdata_i(reg_wdata_i),
    .cause_o(cause_o)
  );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int HOLD_CYC = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pwr_on_i,
  input logic        brown_out_i,
  input logic        sw_rst_i,
  input logic        wdog_i,
  input logic        trap_conf_i,
  input logic        bad_op_i,
  input logic        pin_hit,
  input logic        reg_we_i,
  input logic [15:0] cause_o,
  input logic        sys_rst_o
);
  logic src_any;
  assign src_any = pwr_on_i | brown_out_i | sw_rst_i | wdog_i | trap_conf_i | bad_op_i | pin_hit;

  int idle_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idle_cnt <= 0;
    else if (src_any)            idle_cnt <= 0;
    else if (idle_cnt < HOLD_CYC + 2) idle_cnt <= idle_cnt + 1;
  end

  assert_src_asserts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_any |=> sys_rst_o);

  assert_hold_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> idle_cnt == HOLD_CYC);

  assert_pwr_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_on_i |=> cause_o == 16'h0001);

  assert_write_no_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && !src_any) |=> !sys_rst_o);

  assert_write_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && reg_we_i && !src_any) |=> $stable(cause_o));

  assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_i && !pwr_on_i) |=> cause_o[2]);

  assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o & 16'h3F38) == 16'h0000);
endmodule

bind rst_cause_ctrl rst_cause_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_on_i   (pwr_on_i),
  .brown_out_i(brown_out_i),
  .sw_rst_i   (sw_rst_i),
  .wdog_i     (wdog_i),
  .trap_conf_i(trap_conf_i),
  .bad_op_i   (bad_op_i),
  .pin_hit    (pin_hit),
  .reg_we_i   (reg_we_i),
  .cause_o    (cause_o),
  .sys_rst_o  (sys_rst_o)
);

// File: tb/rst_cause_ctrl_test.sv
`timescale 1ns/1ps
module rst_cause_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr = 0, brown = 0, clr_n = 1, sw = 0, wdog = 0, trap = 0, badop = 0;
  logic        we = 0;
  logic [15:0] wdata = '0;
  logic [15:0] cause;
  logic        sysrst;

  int n_chk = 0;
  int n_bad = 0;
  string cur = "R3";

  always #5 clk = ~clk;

  rst_cause_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_i(pwr), .brown_out_i(brown),
    .ext_clr_ni(clr_n), .sw_rst_i(sw), .wdog_i(wdog), .trap_conf_i(trap),
    .bad_op_i(badop), .reg_we_i(we), .reg_wdata_i(wdata),
    .cause_o(cause), .sys_rst_o(sysrst)
  );

  // behavioural reference
  int          m_hold, m_fcnt;
  logic        m_pin;
  logic [15:0] m_cause;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 16; m_fcnt = 0; m_pin = 0; m_cause = 16'h0001;
    end else begin
      logic req;
      logic [15:0] ev;
      req = pwr | brown | m_pin | sw | wdog | trap | badop;
      ev = '0;
      if (brown) ev[1] = 1; if (wdog) ev[2] = 1; if (sw) ev[6] = 1;
      if (m_pin) ev[7] = 1; if (badop) ev[14] = 1; if (trap) ev[15] = 1;
      if (pwr) m_cause = 16'h0001;
      else begin
        if (we && m_hold == 0) m_cause = wdata & 16'hC0C7;
        m_cause = m_cause | ev;
      end
      if (req) m_hold = 16; else if (m_hold > 0) m_hold = m_hold - 1;
      if (!clr_n != m_pin) begin
        m_fcnt++;
        if (m_fcnt == 4) begin m_pin = !clr_n; m_fcnt = 0; end
      end else m_fcnt = 0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({cur, " sys_rst"}, 32'(sysrst), 32'(m_hold != 0));
    check({cur, " cause"}, 32'(cause), 32'(m_cause));
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    we = 1; wdata = v; step(); we = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    check("R3 reset sys_rst", 32'(sysrst), 1);
    check("R3 reset cause", 32'(cause), 32'h0001);
    cur = "R2"; step(20);
    check("R2 idle release", 32'(sysrst), 0);

    // R2 hold length, R1/R4 brown-out
    cur = "R1"; brown = 1; step(); brown = 0;
    check("R1 brown asserts", 32'(sysrst), 1);
    check("R4 brown bit", 32'(cause), 32'h0003);
    cur = "R2"; step(15);
    check("R2 still held at 15", 32'(sysrst), 1);
    step();
    check("R2 released at 16", 32'(sysrst), 0);

    cur = "R7"; wr(16'h0000); step();
    check("R7 write clear", 32'(cause), 32'h0000);
    check("R7 write no reset", 32'(sysrst), 0);
    cur = "R10"; wr(16'hFFFF); step();
    check("R10 reserved zero", 32'(cause), 32'hC0C7);
    check("R7 write all no reset", 32'(sysrst), 0);
    wr(16'h0000);

    cur = "R9"; wdog = 1; we = 1; wdata = 16'h0000; step(); wdog = 0; we = 0;
    check("R9 event beats clear", 32'(cause), 32'h0004);
    cur = "R8"; wr(16'h0000); step();
    check("R8 write blocked", 32'(cause), 32'h0004);
    step(20);

    cur = "R6"; trap = 1; step(); trap = 0; step(20);
    badop = 1; step(); badop = 0; step(20);
    check("R6 sticky", 32'(cause), 32'hC004);
    cur = "R4"; sw = 1; step(); sw = 0;
    check("R4 sw bit", 32'(cause[6]), 1);
    check("R1 sw asserts", 32'(sysrst), 1);
    step(20);

    cur = "R11"; clr_n = 0; step(3); clr_n = 1; step(2);
    check("R11 short pulse sys_rst", 32'(sysrst), 0);
    check("R11 short pulse bit", 32'(cause[7]), 0);
    clr_n = 0; step(6);
    check("R11 long pulse sys_rst", 32'(sysrst), 1);
    check("R4 pin bit", 32'(cause[7]), 1);
    clr_n = 1; step(19);
    check("R11 release held", 32'(sysrst), 1);
    step(2);
    check("R11 release done", 32'(sysrst), 0);

    cur = "R5"; pwr = 1; step(); pwr = 0;
    check("R5 pwr clears", 32'(cause), 32'h0001);
    step(20);
    check("R5 final release", 32'(sysrst), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule